// File: doc/BRIEF.md
# CPU Address Window Decoder

This block sits on the CPU side of a host bridge and decides, for every CPU address presented to it, which of three programmable windows the address falls into: one window that leads to I/O space on the expansion bus and two that lead to its memory space. Each window is described by a lower-bound register and an upper-bound register. Both are counted in 2 MB units and are written over a simple 32-bit register port. The block reports a hit flag for each window, a prioritised one-hot selection, and the start address and byte length that are currently in force for each window.

A further 4 KB window exposes the bridge's own register file. Its placement comes from a dedicated register, and it is pushed clear of two fixed reserved address holes. A write that would describe a window whose lower bound lies above its upper bound is stored in the register but leaves the window that is in force untouched. The block forwards no traffic and performs no address translation. It only holds the translation (remap) values so that a neighbouring block can use them.

Top module: `cpu_window_decoder`

## Requirements
- R1: After a synchronous active-low reset the registers read back as follows: index 0 (I/O low) 0x080, index 1 (I/O high) 0x0F, index 2 (mem0 low) 0x090, index 3 (mem0 high) 0x1F, index 4 (mem1 low) 0x790, index 5 (mem1 high) 0x1F, index 6 (register window) 0x0A0, and indices 8, 9 and 10 (remap for I/O, mem0, mem1) 0x080, 0x090 and 0x790. The windows in force are I/O at 0x10000000 with length 0x2000000, mem0 at 0x12000000 with length 0x2000000, and mem1 at 0xF2000000 with length 0x2000000.
- R2: A write keeps only bits 14:0 of the data for a low register and for the register-window register, only bits 6:0 for a high register, and only bits 10:0 for a remap register. All other bits read back as zero.
- R3: A write to a window's low register also loads that window's remap register with bits 10:0 of the same data word. A write to a remap index (8 + window number) loads only that remap register.
- R4: One clock after a write to a window's low or high register, provided the new low[6:0] is less than or equal to the new high, the window's start becomes low << 21 and its length becomes (high + 1 - low[6:0]) × 2 MB.
- R5: A write that leaves low[6:0] greater than high is stored in the register, but the start and length of that window keep their previous values.
- R6: Window k reports a hit exactly when its length is non-zero and start ≤ cpu_addr < start + length. The check is combinational on cpu_addr.
- R7: win_sel has at most one bit set. It selects the lowest-numbered window that hits: I/O (bit 0) first, then mem0 (bit 1), then mem1 (bit 2).
- R8: The register window is 4 KB long. Its start is the register value << 21 (address bits 35:21), updated one clock after the write, and isd_hit is set exactly when start ≤ cpu_addr < start + 0x1000.
- R9: A register-window start that falls inside the hole 0x1E000000–0x1F0FFFFF is moved up to 0x1F100000. A start that falls inside the hole 0x1FC00000–0x1FCFFFFF is moved up to 0x1FD00000.
- R10: Writes to indices 7 and 11–15 change no register and no window, and reads from those indices return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_widx | input | 4 | Register index for the write |
| reg_wdata | input | 32 | Write data |
| reg_ridx | input | 4 | Register index for the read |
| reg_rdata | output | 32 | Read data for reg_ridx (combinational) |
| cpu_addr | input | 36 | CPU address to decode |
| win_hit | output | 3 | Hit per window: bit 0 I/O, bit 1 mem0, bit 2 mem1 |
| win_sel | output | 3 | Prioritised one-hot window selection |
| win_start | output | 3×36 | Start address in force, per window |
| win_len | output | 3×36 | Length in bytes in force, per window |
| isd_start | output | 36 | Start of the 4 KB register window after hole clipping |
| isd_hit | output | 1 | cpu_addr lies inside the register window |

## Verification
The hardest situation to reach is an inverted write landing on a window whose registers have already drifted from the mapping in force. After that write, the register contents, the remap value and the live window all hold different histories, and only a sequence of writes can produce this. The random stimulus therefore draws low values mostly from a small range, so that inverted and overlapping windows occur often. It then probes addresses exactly at each window's first byte, its last byte and the bytes one before and one after. Directed writes place the register window on every 2 MB slot that touches a reserved hole.

// File: rtl/cwd_pkg.sv
// Package: shared constants for the CPU address window decoder.
// Assumes 2 MB window granularity and a 36-bit CPU address.
package cwd_pkg;
    localparam int ADDR_W  = 36;   // CPU address width
    localparam int DATA_W  = 32;   // register port width
    localparam int REG_AW  = 4;    // register index width
    localparam int UNIT_SH = 21;   // log2 of the 2 MB window unit
    localparam int LO_W    = 15;   // low-bound field width
    localparam int HI_W    = 7;    // high-bound field width
    localparam int RMP_W   = 11;   // remap field width
    localparam int NWIN    = 3;    // number of programmable windows
endpackage

// File: rtl/cwd_regbank.sv
// Module: cwd_regbank
// Holds the low, high and remap registers of each window and the placement
// register of the internal window. It applies the field masks on write,
// presents the value each register will hold after the current write, and
// serves a combinational read port.
// Assumes one write per clock. Index layout: 2k = low of window k,
// 2k+1 = high of window k, 2*NWIN = internal window, 2*NWIN+2+k = remap k.
module cwd_regbank #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 4,
    parameter int LO_W   = 15,
    parameter int HI_W   = 7,
    parameter int RMP_W  = 11,
    parameter int NWIN   = 3,
    parameter logic [NWIN-1:0][LO_W-1:0] LO_RST = '0,
    parameter logic [NWIN-1:0][HI_W-1:0] HI_RST = '0,
    parameter logic [LO_W-1:0]           ISD_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [REG_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [NWIN-1:0]   upd,
    output logic [LO_W-1:0]   nxt_lo [NWIN],
    output logic [HI_W-1:0]   nxt_hi [NWIN],
    output logic              isd_upd,
    output logic [LO_W-1:0]   isd_nxt
);
    localparam int ISD_IDX  = 2 * NWIN;
    localparam int RMP_BASE = 2 * NWIN + 2;

    logic [LO_W-1:0]  lo_q  [NWIN];
    logic [HI_W-1:0]  hi_q  [NWIN];
    logic [RMP_W-1:0] rmp_q [NWIN];
    logic [LO_W-1:0]  isd_q;
    logic [NWIN-1:0]  lo_wr, hi_wr, rm_wr;

    // Decode the write strobe per register and form the post-write values.
    always_comb begin
        for (int k = 0; k < NWIN; k++) begin
            lo_wr[k]  = wr_en && (wr_idx == REG_AW'(2 * k));
            hi_wr[k]  = wr_en && (wr_idx == REG_AW'(2 * k + 1));
            rm_wr[k]  = wr_en && (wr_idx == REG_AW'(RMP_BASE + k));
            nxt_lo[k] = lo_wr[k] ? wr_data[LO_W-1:0] : lo_q[k];
            nxt_hi[k] = hi_wr[k] ? wr_data[HI_W-1:0] : hi_q[k];
            upd[k]    = lo_wr[k] | hi_wr[k];
        end
        isd_upd = wr_en && (wr_idx == REG_AW'(ISD_IDX));
        isd_nxt = isd_upd ? wr_data[LO_W-1:0] : isd_q;
    end

    // Register state: reset to the boot layout, then follow masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NWIN; k++) begin
                lo_q[k]  <= LO_RST[k];
                hi_q[k]  <= HI_RST[k];
                rmp_q[k] <= LO_RST[k][RMP_W-1:0];
            end
            isd_q <= ISD_RST;
        end else begin
            for (int k = 0; k < NWIN; k++) begin
                lo_q[k] <= nxt_lo[k];
                hi_q[k] <= nxt_hi[k];
                if (lo_wr[k])
                    rmp_q[k] <= wr_data[RMP_W-1:0];
                else if (rm_wr[k])
                    rmp_q[k] <= wr_data[RMP_W-1:0];
            end
            isd_q <= isd_nxt;
        end
    end

    // Read port: zero-extended field, zero for unassigned indices.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (rd_idx == REG_AW'(2 * k))        rd_data = DATA_W'(lo_q[k]);
            if (rd_idx == REG_AW'(2 * k + 1))    rd_data = DATA_W'(hi_q[k]);
            if (rd_idx == REG_AW'(RMP_BASE + k)) rd_data = DATA_W'(rmp_q[k]);
        end
        if (rd_idx == REG_AW'(ISD_IDX)) rd_data = DATA_W'(isd_q);
    end

    // A low write lands in the low register and its remap copy together.
    for (genvar g = 0; g < NWIN; g++) begin : g_chk
        a_r3_remap_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
            lo_wr[g] |=> (rmp_q[g] == $past(wr_data[RMP_W-1:0])));
        a_r2_high_masked: assert property (@(posedge clk) disable iff (!rst_n)
            hi_wr[g] |=> (hi_q[g] == $past(wr_data[HI_W-1:0])));
        a_r2_low_masked: assert property (@(posedge clk) disable iff (!rst_n)
            lo_wr[g] |=> (lo_q[g] == $past(wr_data[LO_W-1:0])));
    end
endmodule

// File: rtl/cwd_window.sv
// Module: cwd_window
// One programmable window. It keeps the start and span (in 2 MB units) that
// are in force, replaces them only when a write yields low[HI_W-1:0] <= high,
// and compares the address against [start, start + span).
// Assumes ADDR_W == LO_W + SH, so that the address unit field covers the upper bits.
module cwd_window #(
    parameter int ADDR_W = 36,
    parameter int LO_W   = 15,
    parameter int HI_W   = 7,
    parameter int SH     = 21,
    parameter logic [LO_W-1:0] LO_RST = '0,
    parameter logic [HI_W-1:0] HI_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [LO_W-1:0]   nxt_lo,
    input  logic [HI_W-1:0]   nxt_hi,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [LO_W-1:0]   base_q,
    output logic [HI_W:0]     span_q
);
    localparam int SPAN_W = HI_W + 1;
    localparam logic [SPAN_W-1:0] RST_SPAN =
        SPAN_W'(HI_RST) + SPAN_W'(1) - SPAN_W'(LO_RST[HI_W-1:0]);

    logic              shape_ok;
    logic [SPAN_W-1:0] new_span;
    logic [LO_W-1:0]   a_u;
    logic [LO_W:0]     end_u;

    // Judge the written pair and compute the span it would give.
    always_comb begin
        shape_ok = (nxt_lo[HI_W-1:0] <= nxt_hi);
        new_span = SPAN_W'(nxt_hi) + SPAN_W'(1) - SPAN_W'(nxt_lo[HI_W-1:0]);
    end

    // Mapping in force: rebuilt only by a well-formed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= LO_RST;
            span_q <= RST_SPAN;
        end else if (upd && shape_ok) begin
            base_q <= nxt_lo;
            span_q <= new_span;
        end
    end

    // Range compare in window units; an empty span never hits.
    always_comb begin
        a_u   = addr[SH +: LO_W];
        end_u = {1'b0, base_q} + (LO_W+1)'(span_q);
        hit   = (span_q != '0) && (a_u >= base_q) && ({1'b0, a_u} < end_u);
    end

    a_r5_inverted_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (nxt_lo[HI_W-1:0] > nxt_hi)) |=> ($stable(base_q) && $stable(span_q)));
    a_r4_good_write_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (nxt_lo[HI_W-1:0] <= nxt_hi)) |=> (base_q == $past(nxt_lo)));
endmodule

// File: rtl/cwd_isd_place.sv
// Module: cwd_isd_place
// Places the fixed-size internal register window. The start is the register
// value scaled to window units and lifted out of either reserved hole. The
// module then reports whether the address falls in the window.
// Assumes both holes lie below 2**ADDR_W and the window size is fixed.
module cwd_isd_place #(
    parameter int ADDR_W    = 36,
    parameter int LO_W      = 15,
    parameter int SH        = 21,
    parameter logic [LO_W-1:0]   ISD_RST   = '0,
    parameter logic [ADDR_W-1:0] ISD_BYTES = ADDR_W'(4096),
    parameter logic [ADDR_W-1:0] H0_LO     = ADDR_W'(32'h1E00_0000),
    parameter logic [ADDR_W-1:0] H0_TOP    = ADDR_W'(32'h1F10_0000),
    parameter logic [ADDR_W-1:0] H1_LO     = ADDR_W'(32'h1FC0_0000),
    parameter logic [ADDR_W-1:0] H1_TOP    = ADDR_W'(32'h1FD0_0000)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic [LO_W-1:0]   nxt_val,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] start_q,
    output logic              hit
);
    // Scale to bytes, then lift a start out of each hole in turn.
    function automatic logic [ADDR_W-1:0] place(input logic [LO_W-1:0] v);
        logic [ADDR_W-1:0] b;
        b = ADDR_W'(v) << SH;
        if (b >= H0_LO && b < H0_TOP) b = H0_TOP;
        if (b >= H1_LO && b < H1_TOP) b = H1_TOP;
        return b;
    endfunction

    localparam logic [ADDR_W-1:0] RST_START = place(ISD_RST);

    logic [ADDR_W:0] end_b;

    // Start in force, recomputed when its register is written.
    always_ff @(posedge clk) begin
        if (!rst_n)   start_q <= RST_START;
        else if (upd) start_q <= place(nxt_val);
    end

    // Byte-exact membership test over the fixed window size.
    always_comb begin
        end_b = {1'b0, start_q} + {1'b0, ISD_BYTES};
        hit   = (addr >= start_q) && ({1'b0, addr} < end_b);
    end

    a_r9_start_clear_of_holes: assert property (@(posedge clk) disable iff (!rst_n)
        !((start_q >= H0_LO) && (start_q < H0_TOP)) &&
        !((start_q >= H1_LO) && (start_q < H1_TOP)));
    a_r8_start_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && (nxt_val == '0)) |=> (start_q == '0));
endmodule

// File: rtl/cpu_window_decoder.sv
// Module: cpu_window_decoder (top)
// Decodes a CPU address against three programmable windows (I/O, mem0, mem1)
// and the internal register window, and resolves overlaps by fixed priority.
// Assumes a single clock, a synchronous active-low reset, and that the address
// is stable for the cycle in which the outputs are used.
module cpu_window_decoder
    import cwd_pkg::*;
#(
    parameter logic [NWIN-1:0][LO_W-1:0] LO_RST  = {15'h790, 15'h090, 15'h080},
    parameter logic [NWIN-1:0][HI_W-1:0] HI_RST  = {7'h1F, 7'h1F, 7'h0F},
    parameter logic [LO_W-1:0]           ISD_RST = 15'h0A0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_widx,
    input  logic [DATA_W-1:0]           reg_wdata,
    input  logic [REG_AW-1:0]           reg_ridx,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [ADDR_W-1:0]           cpu_addr,
    output logic [NWIN-1:0]             win_hit,
    output logic [NWIN-1:0]             win_sel,
    output logic [NWIN-1:0][ADDR_W-1:0] win_start,
    output logic [NWIN-1:0][ADDR_W-1:0] win_len,
    output logic [ADDR_W-1:0]           isd_start,
    output logic                        isd_hit
);
    logic [NWIN-1:0] upd;
    logic [LO_W-1:0] nxt_lo [NWIN];
    logic [HI_W-1:0] nxt_hi [NWIN];
    logic            isd_upd;
    logic [LO_W-1:0] isd_nxt;

    cwd_regbank #(
        .DATA_W(DATA_W), .REG_AW(REG_AW), .LO_W(LO_W), .HI_W(HI_W),
        .RMP_W(RMP_W), .NWIN(NWIN), .LO_RST(LO_RST), .HI_RST(HI_RST),
        .ISD_RST(ISD_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .wr_idx(reg_widx),
        .wr_data(reg_wdata), .rd_idx(reg_ridx), .rd_data(reg_rdata),
        .upd(upd), .nxt_lo(nxt_lo), .nxt_hi(nxt_hi),
        .isd_upd(isd_upd), .isd_nxt(isd_nxt)
    );

    for (genvar k = 0; k < NWIN; k++) begin : g_win
        logic [LO_W-1:0] base_u;
        logic [HI_W:0]   span_u;

        cwd_window #(
            .ADDR_W(ADDR_W), .LO_W(LO_W), .HI_W(HI_W), .SH(UNIT_SH),
            .LO_RST(LO_RST[k]), .HI_RST(HI_RST[k])
        ) u_win (
            .clk(clk), .rst_n(rst_n), .upd(upd[k]),
            .nxt_lo(nxt_lo[k]), .nxt_hi(nxt_hi[k]), .addr(cpu_addr),
            .hit(win_hit[k]), .base_q(base_u), .span_q(span_u)
        );

        // Express the window in byte addresses.
        assign win_start[k] = ADDR_W'(base_u) << UNIT_SH;
        assign win_len[k]   = ADDR_W'(span_u) << UNIT_SH;
    end

    cwd_isd_place #(
        .ADDR_W(ADDR_W), .LO_W(LO_W), .SH(UNIT_SH), .ISD_RST(ISD_RST)
    ) u_isd (
        .clk(clk), .rst_n(rst_n), .upd(isd_upd), .nxt_val(isd_nxt),
        .addr(cpu_addr), .start_q(isd_start), .hit(isd_hit)
    );

    // Priority pick: the lowest-numbered hitting window wins.
    always_comb begin
        logic found;
        found   = 1'b0;
        win_sel = '0;
        for (int k = 0; k < NWIN; k++) begin
            if (win_hit[k] && !found) begin
                win_sel[k] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_sel));
    a_r7_sel_only_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_sel & ~win_hit) == '0));
    a_r7_io_wins: assert property (@(posedge clk) disable iff (!rst_n)
        win_hit[0] |-> win_sel[0]);
    a_r7_any_hit_selects: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit != '0) |-> (win_sel != '0));
endmodule

// File: tb/cpu_window_decoder_bench.sv
`timescale 1ns/1ps
module cpu_window_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_widx = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_ridx = '0;
    logic [31:0] reg_rdata;
    logic [35:0] cpu_addr = '0;
    logic [2:0]  win_hit, win_sel;
    logic [2:0][35:0] win_start, win_len;
    logic [35:0] isd_start;
    logic        isd_hit;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state.
    logic [14:0] mlo [3];
    logic [6:0]  mhi [3];
    logic [10:0] mrem [3];
    logic [14:0] mst [3];
    logic [7:0]  mln [3];
    logic [14:0] misd;

    cpu_window_decoder u_cpu_window_decoder (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_widx(reg_widx),
        .reg_wdata(reg_wdata), .reg_ridx(reg_ridx), .reg_rdata(reg_rdata),
        .cpu_addr(cpu_addr), .win_hit(win_hit), .win_sel(win_sel),
        .win_start(win_start), .win_len(win_len), .isd_start(isd_start),
        .isd_hit(isd_hit)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic void model_reset();
        mlo[0] = 15'h080; mhi[0] = 7'h0F;
        mlo[1] = 15'h090; mhi[1] = 7'h1F;
        mlo[2] = 15'h790; mhi[2] = 7'h1F;
        for (int k = 0; k < 3; k++) begin
            mrem[k] = mlo[k][10:0];
            mst[k]  = mlo[k];
            mln[k]  = 8'(mhi[k]) + 8'd1 - 8'(mlo[k][6:0]);
        end
        misd = 15'h0A0;
    endfunction

    function automatic void model_write(input int idx, input logic [31:0] d);
        if (idx < 6) begin
            int k;
            k = idx / 2;
            if (idx % 2 == 0) begin
                mlo[k] = d[14:0];
                mrem[k] = d[10:0];
            end else begin
                mhi[k] = d[6:0];
            end
            if (mlo[k][6:0] <= mhi[k]) begin
                mst[k] = mlo[k];
                mln[k] = 8'(mhi[k]) + 8'd1 - 8'(mlo[k][6:0]);
            end
        end else if (idx == 6) begin
            misd = d[14:0];
        end else if (idx >= 8 && idx <= 10) begin
            mrem[idx-8] = d[10:0];
        end
    endfunction

    function automatic logic [31:0] exp_reg(input int idx);
        if (idx < 6) return (idx % 2 == 0) ? 32'(mlo[idx/2]) : 32'(mhi[idx/2]);
        if (idx == 6) return 32'(misd);
        if (idx >= 8 && idx <= 10) return 32'(mrem[idx-8]);
        return 32'h0;
    endfunction

    function automatic logic [35:0] exp_isd_start();
        logic [35:0] s;
        s = 36'(misd) << 21;
        if (s >= 36'h1E00_0000 && s < 36'h1F10_0000) return 36'h1F10_0000;
        if (s >= 36'h1FC0_0000 && s < 36'h1FD0_0000) return 36'h1FD0_0000;
        return s;
    endfunction

    function automatic logic exp_hit(input int k, input logic [35:0] a);
        logic [15:0] u;
        u = 16'(a[35:21]);
        return (mln[k] != 0) && (u >= 16'(mst[k])) && (u < 16'(mst[k]) + 16'(mln[k]));
    endfunction

    task automatic do_write(input int idx, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_widx = 4'(idx); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        model_write(idx, d);
    endtask

    task automatic check_regs(input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            reg_ridx = 4'(i);
            #1;
            chk($sformatf("%s reg idx %0d", tag, i), 64'(reg_rdata), 64'(exp_reg(i)));
        end
    endtask

    task automatic check_outs(input logic [35:0] a);
        logic [2:0] eh, es;
        logic [35:0] is;
        cpu_addr = a;
        #1;
        eh = '0; es = '0;
        for (int k = 0; k < 3; k++) eh[k] = exp_hit(k, a);
        for (int k = 0; k < 3; k++) if (eh[k] && es == 3'b000) es[k] = 1'b1;
        chk($sformatf("R6 win_hit @%h", a), 64'(win_hit), 64'(eh));
        chk($sformatf("R7 win_sel @%h", a), 64'(win_sel), 64'(es));
        for (int k = 0; k < 3; k++) begin
            chk($sformatf("R4 R5 start win%0d", k), 64'(win_start[k]), 64'(36'(mst[k]) << 21));
            chk($sformatf("R4 R5 len win%0d", k), 64'(win_len[k]), 64'(36'(mln[k]) << 21));
        end
        is = exp_isd_start();
        chk("R8 R9 isd_start", 64'(isd_start), 64'(is));
        chk($sformatf("R8 isd_hit @%h", a), 64'(isd_hit),
            64'((a >= is) && (37'(a) < 37'(is) + 37'h1000)));
    endtask

    task automatic probe_edges(input int k);
        logic [35:0] b, e;
        b = 36'(mst[k]) << 21;
        e = b + (36'(mln[k]) << 21);
        check_outs(b - 36'd1);
        check_outs(b);
        check_outs(e - 36'd1);
        check_outs(e);
    endtask

    task automatic probe_isd();
        logic [35:0] s;
        s = exp_isd_start();
        check_outs(s - 36'd1);
        check_outs(s);
        check_outs(s + 36'hFFF);
        check_outs(s + 36'h1000);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and reset windows.
        check_regs("R1");
        check_outs(36'h0);
        chk("R1 io start", 64'(win_start[0]), 64'h1000_0000);
        chk("R1 io len", 64'(win_len[0]), 64'h0200_0000);
        chk("R1 m0 start", 64'(win_start[1]), 64'h1200_0000);
        chk("R1 m1 start", 64'(win_start[2]), 64'hF200_0000);
        chk("R1 isd start", 64'(isd_start), 64'h1400_0000);

        // R6: boundaries of the reset windows.
        for (int k = 0; k < 3; k++) probe_edges(k);
        probe_isd();

        // R2 R3 R5: all-ones low write is masked, copied to remap, and inverted.
        do_write(0, 32'hFFFF_FFFF);
        check_regs("R2 R3 R5");
        check_outs(36'h1000_0000);
        chk("R5 io start unchanged", 64'(win_start[0]), 64'h1000_0000);
        do_write(0, 32'h0000_0080);
        // R2 R4: high write keeps bits 6:0 and reshapes the window.
        do_write(1, 32'hFFFF_FF85);
        chk("R2 io high masked", 64'(win_len[0]), 64'(36'd6 << 21));
        probe_edges(0);
        // R3: direct remap write.
        do_write(8, 32'hFFFF_FFFF);
        check_regs("R3 R2 remap");

        // R7: overlapping windows, priority I/O then mem0 then mem1.
        do_write(1, 32'h0F);
        do_write(2, 32'h080); do_write(3, 32'h1F);
        do_write(4, 32'h080); do_write(5, 32'h2F);
        check_outs(36'h1000_0000);
        chk("R7 io first", 64'(win_sel), 64'h1);
        check_outs(36'h1200_0000);
        chk("R7 mem0 next", 64'(win_sel), 64'h2);
        check_outs(36'h1400_0000);
        chk("R7 mem1 last", 64'(win_sel), 64'h4);

        // R8 R9: internal window on every slot touching a hole.
        for (int v = 8'hEF; v <= 8'hFF; v++) begin
            do_write(6, 32'(v));
            probe_isd();
        end

        // R10: unassigned indices.
        do_write(7, 32'hFFFF_FFFF);
        do_write(11, 32'h1234_5678);
        do_write(15, 32'hFFFF_FFFF);
        check_regs("R10");
        check_outs(36'h1000_0000);

        // Random mix of writes and boundary probes.
        for (int it = 0; it < 600; it++) begin
            int op, k;
            op = int'($urandom % 6);
            k  = int'($urandom % 3);
            case (op)
                0: do_write(2 * k, ($urandom % 2) ? ($urandom & 32'h7F) : $urandom);
                1: do_write(2 * k + 1, ($urandom % 2) ? ($urandom & 32'h3F) : $urandom);
                2: do_write(6, ($urandom % 2) ? (32'hEC + ($urandom % 20)) : $urandom);
                3: do_write(int'($urandom % 16), $urandom);
                4: probe_edges(k);
                default: begin
                    probe_isd();
                    check_outs({4'($urandom), $urandom});
                end
            endcase
            if (it % 100 == 99) check_regs("R2 R3 R10 random");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule